// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational 32-bit arithmetic logic unit. It is built from a chain of identical one-bit slices joined by a plain ripple carry. It takes two operands and a three-bit operation code. It returns a result word, a flag that is set when the result is all zeros, and a signed overflow flag.

Five operations are defined: bitwise AND, bitwise OR, add, subtract and signed set-on-less-than. The top bit of the operation code does two jobs. It inverts operand B, and it also drives the carry into bit 0, so subtract and compare both compute A + ~B + 1. The low two bits of the code choose what each slice outputs: the AND term, the OR term, the sum, or the slice's "less" input.

For a compare, the top slice derives a set bit from the sign of the difference, corrected by overflow. That set bit is routed back into the less input of bit 0, and every other less input is tied to 0. Equality is tested by subtracting and reading the zero flag.

Top module: `ripple_alu`

## Requirements
- R1: Operation code 000 returns the bitwise AND of A and B.
- R2: Operation code 001 returns the bitwise OR of A and B.
- R3: Operation code 010 returns A + B modulo 2^32; a carry out of bit 31 is discarded and does not by itself raise overflow.
- R4: Operation code 110 returns A − B modulo 2^32.
- R5: Operation code 111 returns 1 in bit 0 when A is less than B as signed two's complement values, and 0 otherwise, with bits 31..1 always 0. This holds even when A − B overflows.
- R6: The zero flag is 1 exactly when all 32 result bits are 0; in particular, subtracting equal operands sets it.
- R7: For add, overflow is 1 exactly when both operands have the same sign bit (bit 31) and the result's sign bit differs from it.
- R8: For subtract, overflow is 1 exactly when the operands' sign bits differ and the result's sign bit differs from A's sign bit.
- R9: Overflow is 0 for AND, OR and set-on-less-than, whatever the operands.
- R10: Unused operation codes 011, 100 and 101 return a result of 0, so the zero flag is 1 and overflow is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand A |
| opb | input | 32 | Second operand B |
| op | input | 3 | Operation code |
| res | output | 32 | Result word |
| is_zero | output | 1 | High when res is all zeros |
| ovf | output | 1 | Signed overflow for add and subtract |

## Verification
The checker's assertions are immediate checks, evaluated whenever the inputs settle. They take for granted that all three inputs hold known two-state values and that the operation code is one of the eight encodings. The bench drives every input from two-state variables and changes them only at a clock edge, then compares half a period later once the ripple chain has settled. Stimulus therefore never shows the checker an undefined or mid-transition operand.

// File: rtl/ripple_alu.sv
module ripple_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       op,
  output logic [WIDTH-1:0] res,
  output logic             is_zero,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic             invert_b;
  logic [1:0]       pick;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] bx;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] less;
  logic [WIDTH-1:0] slice_out;
  logic             raw_ovf;
  logic             set_bit;
  logic             op_known;
  logic             op_arith;

  assign invert_b = op[2];
  assign pick     = op[1:0];
  assign carry[0] = invert_b;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_slice
      assign bx[i]        = opb[i] ^ invert_b;
      assign sum[i]       = opa[i] ^ bx[i] ^ carry[i];
      assign carry[i+1]   = (opa[i] & bx[i]) | (opa[i] & carry[i]) | (bx[i] & carry[i]);
      always_comb begin
        case (pick)
          2'b00:   slice_out[i] = opa[i] & bx[i];
          2'b01:   slice_out[i] = opa[i] | bx[i];
          2'b10:   slice_out[i] = sum[i];
          default: slice_out[i] = less[i];
        endcase
      end
      if (i == 0) begin : g_lsb
        assign less[i] = set_bit;
      end else begin : g_upper
        assign less[i] = 1'b0;
      end
    end
  endgenerate

  assign raw_ovf = carry[MSB] ^ carry[WIDTH];
  assign set_bit = sum[MSB] ^ raw_ovf;

  always_comb begin
    case (op)
      3'b000, 3'b001, 3'b010, 3'b110, 3'b111: op_known = 1'b1;
      default:                                op_known = 1'b0;
    endcase
  end

  assign op_arith = (op == 3'b010) || (op == 3'b110);
  assign res      = op_known ? slice_out : '0;
  assign is_zero  = ~|res;
  assign ovf      = op_arith & raw_ovf;
endmodule

module ripple_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] res,
  input logic             is_zero,
  input logic             ovf
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (op == 3'b000) AST_AND_BITS: assert (res == (opa & opb));   // R1
    if (op == 3'b001) AST_OR_BITS: assert (res == (opa | opb));    // R2
    if (op == 3'b010) AST_ADD_SUM: assert (res == opa + opb);      // R3
    if (op == 3'b110) AST_SUB_DIFF: assert (res == opa - opb);     // R4
    if (op == 3'b111) AST_SLT_RESULT: assert (res == {{(WIDTH-1){1'b0}}, ($signed(opa) < $signed(opb))}); // R5
    if (op == 3'b110 && opa == opb) AST_EQ_ZERO: assert (is_zero); // R6
    if (op == 3'b010) AST_ADD_OVF: assert (ovf == ((opa[MSB] == opb[MSB]) && (res[MSB] != opa[MSB]))); // R7
    if (op == 3'b110) AST_SUB_OVF: assert (ovf == ((opa[MSB] != opb[MSB]) && (res[MSB] != opa[MSB]))); // R8
    if (op == 3'b000 || op == 3'b001 || op == 3'b111) AST_NO_OVERFLOW: assert (!ovf); // R9
    if (op == 3'b011 || op == 3'b100 || op == 3'b101) AST_UNUSED_QUIET: assert (res == '0 && is_zero && !ovf); // R10
  end
endmodule

bind ripple_alu ripple_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opa(opa), .opb(opb), .op(op), .res(res), .is_zero(is_zero), .ovf(ovf)
);

// File: tb/ripple_alu_tb.sv
module ripple_alu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  localparam int VW = 3 + 32 + 32 + 32 + 1 + 1;

  // {op, a, b, expected result, expected zero, expected overflow}
  localparam logic [VW-1:0] VEC [0:NV-1] = '{
    {3'b000, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h00F0_000F, 1'b0, 1'b0}, // R1
    {3'b001, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFFF0_0FFF, 1'b0, 1'b0}, // R2
    {3'b010, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 1'b0, 1'b0}, // R3
    {3'b010, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1}, // R7
    {3'b010, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1}, // R7 R6
    {3'b010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0}, // R3
    {3'b110, 32'h0000_000A, 32'h0000_0003, 32'h0000_0007, 1'b0, 1'b0}, // R4
    {3'b110, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000, 1'b1, 1'b0}, // R6
    {3'b110, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R8
    {3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 1'b1}, // R8
    {3'b110, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 1'b0, 1'b0}, // R4
    {3'b111, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0}, // R5
    {3'b111, 32'h0000_0005, 32'h0000_0003, 32'h0000_0000, 1'b1, 1'b0}, // R5
    {3'b111, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0}, // R5 R9
    {3'b111, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R5 R9
    {3'b111, 32'h0000_0042, 32'h0000_0042, 32'h0000_0000, 1'b1, 1'b0}, // R5
    {3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0}, // R10
    {3'b100, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R10
    {3'b101, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R10
    {3'b000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0}  // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [2:0]  op = '0;
  logic [31:0] res;
  logic        is_zero;
  logic        ovf;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ripple_alu u_dut (.opa(opa), .opb(opb), .op(op), .res(res), .is_zero(is_zero), .ovf(ovf));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (op=%b a=%h b=%h)", tag, got, exp, op, opa, opb);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    op = o; opa = a; opb = b;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: AND of zeros, R1 and R6
    check("R1 reset res", res, 32'h0);
    check("R6 reset zero", {31'b0, is_zero}, 32'h1);

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      apply(v[100:98], v[97:66], v[65:34]);
      check($sformatf("vec%0d res R1-R5/R10", k), res, v[33:2]);
      check($sformatf("vec%0d R6 zero", k), {31'b0, is_zero}, {31'b0, v[1]});
      check($sformatf("vec%0d R7/R8/R9 ovf", k), {31'b0, ovf}, {31'b0, v[0]});
    end

    // directed sweep of add, subtract and compare against arithmetic model
    for (int k = 0; k < 64; k++) begin
      logic [31:0] a, b, s;
      logic e_ov;
      a = 32'h9E37_79B9 * k + 32'h1357;
      b = 32'h7F4A_7C15 * (k + 3) ^ 32'h8000_0000;
      apply(3'b010, a, b);
      s = a + b;
      e_ov = (a[31] == b[31]) && (s[31] != a[31]);
      check("R3 sweep add", res, s);
      check("R7 sweep add ovf", {31'b0, ovf}, {31'b0, e_ov});
      apply(3'b110, a, b);
      s = a - b;
      e_ov = (a[31] != b[31]) && (s[31] != a[31]);
      check("R4 sweep sub", res, s);
      check("R8 sweep sub ovf", {31'b0, ovf}, {31'b0, e_ov});
      apply(3'b111, a, b);
      check("R5 sweep slt", res, {31'b0, ($signed(a) < $signed(b))});
      check("R9 sweep slt ovf", {31'b0, ovf}, 32'h0);
    end

    // R10: unused codes with operands that would give nonzero logic output
    apply(3'b100, 32'hA5A5_A5A5, 32'h0F0F_0F0F);
    check("R10 op100 res", res, 32'h0);
    apply(3'b101, 32'hA5A5_A5A5, 32'h0F0F_0F0F);
    check("R10 op101 res", res, 32'h0);
    apply(3'b011, 32'h0000_0000, 32'h0000_0001);
    check("R10 op011 res", res, 32'h0);

    finish_run();
  end
endmodule